// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

The block sits at the serial audio input of a playback chain and pulls one channel out of a serial stream. The stream arrives on three wires: a bit clock, which is also the block's clock, a frame clock and one data line. The stream may use one of three two-channel layouts: I2S, left-justified or right-justified. It may also be a time-division-multiplexed frame of four or eight 32-bit slots. Static configuration inputs choose the layout, the word length for the two-channel layouts, and the channel or slot to keep.

Each time the chosen channel's last bit has arrived, the block presents the captured word left-aligned in a 24-bit output with a one-cycle strobe. It also counts bit clocks from one frame start to the next. A frame whose length is not allowed for the current layout raises a framing-error flag, and strobes are withheld until a frame of legal length has been seen again. The configuration inputs are expected to change only while the block is held in reset.

Top module: `audio_slot_rx`

## Requirements
- R1: After reset `sample_o` is zero and `sample_vld_o` and `frame_err_o` are low. They stay that way while the frame clock is idle. Both `frame_i` and `data_i` are sampled on the rising edge of `clk_i`.
- R2: Left-justified (`cfg_fmt_i` = 1): the left word is sent while `frame_i` is high, and its MSB is in the same bit period as the rising `frame_i` edge. The right word follows the falling edge in the same way.
- R3: I2S (`cfg_fmt_i` = 0): the left word is sent while `frame_i` is low, and its MSB comes one bit period after the `frame_i` edge that opens the half-frame. The right word follows the same rule from the rising edge.
- R4: Right-justified (`cfg_fmt_i` = 2): the left half is high, and the LSB of each word is on the last bit of its half-frame. The word length is set by `cfg_wlen_i` (0 = 16, 1 = 20, 2 or 3 = 24 bits).
- R5: In the two-channel layouts, `cfg_slot_i[0]` selects the channel: 0 = left, 1 = right.
- R6: TDM (`cfg_fmt_i` = 3): a rising `frame_i` edge marks the first bit of slot 0, and slot s starts 32*s bit periods later. Data is MSB first. The upper 24 bits of slot `cfg_slot_i` are captured. `cfg_tdm8_i` = 1 selects eight slots and 0 selects four.
- R7: The captured word is left-aligned in `sample_o[23:0]`, and the bits below the word length are zero. Bits outside the selected word do not reach the output.
- R8: `sample_vld_o` is high for exactly one cycle. It is registered on the clock edge after the edge that samples the channel's last data bit, and `sample_o` updates on that same edge.
- R9: Frame length is counted in bit periods from one frame start to the next. A frame starts at the left-half start, or at the slot-0 start in TDM. The allowed lengths are 32, 48 or 64 in the two-channel layouts, and 128 (four slots) or 256 (eight slots) in TDM. `frame_err_o` changes only at a frame start: it is set when the frame just completed had an illegal length and cleared when it had a legal one.
- R10: `sample_vld_o` stays low unless the most recently completed frame had a legal length. This includes the first frame after reset, and every frame while `frame_err_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_i | input | 1 | Frame (word-select) clock |
| data_i | input | 1 | Serial data line |
| cfg_fmt_i | input | 2 | Layout: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM |
| cfg_wlen_i | input | 2 | Word length for the two-channel layouts: 0 = 16, 1 = 20, 2/3 = 24 bits |
| cfg_slot_i | input | 3 | Channel (bit 0) or TDM slot (all bits) to capture |
| cfg_tdm8_i | input | 1 | TDM frame has 8 slots when high, 4 when low |
| sample_o | output | 24 | Captured word, left-aligned |
| sample_vld_o | output | 1 | One-cycle strobe marking a new `sample_o` |
| frame_err_o | output | 1 | Last completed frame had an illegal length |

## Verification
The data bit driven in period i is sampled on the next rising edge, passes one capture stage, and is flagged on the following edge. The strobe for a word whose last bit was driven in period i therefore shows up when the bench is about to drive period i+2. For every scenario, the bench computes the index of the selected channel's last bit from the layout and the word length. It then checks the strobe against that index.

The frame-error flag responds at the start of the frame after the measured one. In I2S it responds one period later, because of the internal realignment. For this reason each scenario ends with a few bits of a new frame before the flag is read. The bench drives all inputs and samples all outputs on the falling clock edge. It counts strobes across whole frames, which lets it check that the first frame after reset and any frame following an illegal one produce none.

// File: rtl/asr_pkg.sv
package asr_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_TDM = 2'd3
  } fmt_e;

  // word length code to bit count
  function automatic int unsigned wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction

  // legal frame lengths per layout
  function automatic logic frame_len_ok(input int unsigned len,
                                        input logic        tdm,
                                        input logic        tdm8,
                                        input int unsigned slot_w);
    if (tdm) begin
      return len == (tdm8 ? 8 * slot_w : 4 * slot_w);
    end
    return (len == 32) || (len == 48) || (len == 64);
  endfunction

endpackage

// File: rtl/asr_frame_track.sv
module asr_frame_track
  import asr_pkg::*;
#(
  parameter int FW     = 9,
  parameter int SLOT_W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  fmt_e          fmt_i,
  input  logic          tdm8_i,
  output logic          eff_lvl_o,
  output logic [FW-1:0] fpos_o,
  output logic [FW-1:0] hpos_o,
  output logic [FW-1:0] half_len_o,
  output logic          locked_o,
  output logic          err_o
);

  // frame clock sampling pipeline
  logic frm_q, frm_p, frm_pp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q  <= 1'b0;
      frm_p  <= 1'b0;
      frm_pp <= 1'b0;
    end else begin
      frm_q  <= frame_i;
      frm_p  <= frm_q;
      frm_pp <= frm_p;
    end
  end

  // I2S is realigned: delayed one bit and inverted, so left = high and
  // the first data bit sits on the effective edge in every layout
  logic is_i2s, is_tdm;
  logic eff, eff_prev, rise, edge_any;

  always_comb begin
    is_i2s   = (fmt_i == FMT_I2S);
    is_tdm   = (fmt_i == FMT_TDM);
    eff      = is_i2s ? ~frm_p  : frm_q;
    eff_prev = is_i2s ? ~frm_pp : frm_p;
    rise     = eff & ~eff_prev;
    edge_any = eff ^ eff_prev;
  end

  // position counters and frame length state
  logic [FW-1:0] fpos_q, hpos_q, len_q;
  logic          start_q, locked_q, err_q;
  logic [FW-1:0] fpos_inc, hpos_inc, fpos_d, hpos_d, len_d;
  logic          start_d, locked_d, err_d, len_ok, measure;

  always_comb begin
    fpos_inc = (fpos_q == {FW{1'b1}}) ? fpos_q : fpos_q + 1'b1;
    hpos_inc = (hpos_q == {FW{1'b1}}) ? hpos_q : hpos_q + 1'b1;
    fpos_d   = rise     ? '0 : fpos_inc;
    hpos_d   = edge_any ? '0 : hpos_inc;
    len_ok   = frame_len_ok(32'(fpos_inc), is_tdm, tdm8_i, SLOT_W);
    measure  = rise & start_q;
    start_d  = start_q | rise;
    len_d    = measure ? fpos_inc : len_q;
    locked_d = measure ? len_ok   : locked_q;
    err_d    = measure ? ~len_ok  : err_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fpos_q   <= '0;
      hpos_q   <= '0;
      len_q    <= '0;
      start_q  <= 1'b0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      fpos_q   <= fpos_d;
      hpos_q   <= hpos_d;
      len_q    <= len_d;
      start_q  <= start_d;
      locked_q <= locked_d;
      err_q    <= err_d;
    end
  end

  assign eff_lvl_o  = eff;
  assign fpos_o     = fpos_d;
  assign hpos_o     = hpos_d;
  assign half_len_o = len_q >> 1;
  assign locked_o   = locked_q;
  assign err_o      = err_q;

  AST_ERR_AT_FRAME_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(err_q)); // R9

  AST_LOCK_ON_LEGAL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> frame_len_ok(32'(len_q), is_tdm, tdm8_i, SLOT_W)); // R9

endmodule

// File: rtl/asr_slot_capture.sv
module asr_slot_capture
  import asr_pkg::*;
#(
  parameter int FW     = 9,
  parameter int SW     = 24,
  parameter int SLOT_W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sd_i,
  input  fmt_e          fmt_i,
  input  logic [1:0]    wlen_i,
  input  logic [2:0]    slot_i,
  input  logic          tdm8_i,
  input  logic          eff_lvl_i,
  input  logic [FW-1:0] fpos_i,
  input  logic [FW-1:0] hpos_i,
  input  logic [FW-1:0] half_len_i,
  input  logic          locked_i,
  output logic [SW-1:0] sample_o,
  output logic          valid_o
);

  localparam int IW = $clog2(SW);

  logic          is_tdm, sel_ok, active, last;
  logic [FW-1:0] n_bits, pos, st, k;
  logic [IW-1:0] idx;
  logic [SW-1:0] acc_q, acc_d, smp_q, smp_d;
  logic          vld_q, vld_d;

  // capture window
  always_comb begin
    is_tdm = (fmt_i == FMT_TDM);
    n_bits = is_tdm ? FW'(SW) : FW'(wlen_bits(wlen_i));
    pos    = is_tdm ? fpos_i : hpos_i;
    if (is_tdm) begin
      st     = FW'(32'(slot_i) * SLOT_W);
      sel_ok = tdm8_i | ~slot_i[2];
    end else begin
      st     = (fmt_i == FMT_RJ) ? half_len_i - n_bits : '0;
      sel_ok = eff_lvl_i ^ slot_i[0];
    end
    k      = pos - st;
    active = sel_ok && (pos >= st) && (k < n_bits);
    last   = active && (k == n_bits - 1'b1);
    idx    = IW'(SW - 1) - IW'(k);
  end

  // accumulator and output next state
  always_comb begin
    acc_d = acc_q;
    if (active) begin
      if (k == '0) acc_d = '0;
      acc_d[idx] = sd_i;
    end
    smp_d = last ? acc_d : smp_q;
    vld_d = last & locked_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      smp_q <= smp_d;
      vld_q <= vld_d;
    end
  end

  assign sample_o = smp_q;
  assign valid_o  = vld_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q); // R8

  AST_LEFT_ALIGN_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !is_tdm && wlen_i == 2'd0) |-> (smp_q[SW-17:0] == '0)); // R7

endmodule

// File: rtl/audio_slot_rx.sv
module audio_slot_rx
  import asr_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_W    = 32,
  parameter int MAX_FRAME = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_i,
  input  logic                data_i,
  input  logic [1:0]          cfg_fmt_i,
  input  logic [1:0]          cfg_wlen_i,
  input  logic [2:0]          cfg_slot_i,
  input  logic                cfg_tdm8_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_vld_o,
  output logic                frame_err_o
);

  localparam int FW = $clog2(MAX_FRAME) + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // data line sampling
  logic sd_q;
  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) sd_q <= 1'b0;
    else            sd_q <= data_i;
  end

  fmt_e          fmt;
  logic          eff_lvl, locked, frm_err;
  logic [FW-1:0] fpos, hpos, half_len;

  assign fmt = fmt_e'(cfg_fmt_i);

  asr_frame_track #(
    .FW     (FW),
    .SLOT_W (SLOT_W)
  ) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .frame_i    (frame_i),
    .fmt_i      (fmt),
    .tdm8_i     (cfg_tdm8_i),
    .eff_lvl_o  (eff_lvl),
    .fpos_o     (fpos),
    .hpos_o     (hpos),
    .half_len_o (half_len),
    .locked_o   (locked),
    .err_o      (frm_err)
  );

  asr_slot_capture #(
    .FW     (FW),
    .SW     (SAMPLE_W),
    .SLOT_W (SLOT_W)
  ) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .sd_i       (sd_q),
    .fmt_i      (fmt),
    .wlen_i     (cfg_wlen_i),
    .slot_i     (cfg_slot_i),
    .tdm8_i     (cfg_tdm8_i),
    .eff_lvl_i  (eff_lvl),
    .fpos_i     (fpos),
    .hpos_i     (hpos),
    .half_len_i (half_len),
    .locked_i   (locked),
    .sample_o   (sample_o),
    .valid_o    (sample_vld_o)
  );

  assign frame_err_o = frm_err;

  AST_NO_VALID_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    frame_err_o |-> !sample_vld_o); // R10

endmodule

// File: tb/audio_slot_rx_bench.sv
`timescale 1ns/1ps
module audio_slot_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_i, data_i;
  logic [1:0]  cfg_fmt, cfg_wlen;
  logic [2:0]  cfg_slot;
  logic        cfg_tdm8;
  logic [23:0] sample_o;
  logic        sample_vld_o, frame_err_o;

  always #2.5 clk = ~clk;

  audio_slot_rx u_audio_slot_rx (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_i      (frame_i),
    .data_i       (data_i),
    .cfg_fmt_i    (cfg_fmt),
    .cfg_wlen_i   (cfg_wlen),
    .cfg_slot_i   (cfg_slot),
    .cfg_tdm8_i   (cfg_tdm8),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld_o),
    .frame_err_o  (frame_err_o)
  );

  int total = 0;
  int bad   = 0;
  int bitn  = 0;
  int nval  = 0;
  int exp_vb;
  int wbits;
  logic        idle_lvl;
  logic [23:0] vs [0:31];
  int          vb [0:31];
  logic [31:0] tdm_w [0:7];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit period: observe outputs, then drive the next bit
  task automatic tick(input logic f, input logic d);
    @(negedge clk);
    if (sample_vld_o) begin
      if (nval < 32) begin
        vs[nval] = sample_o;
        vb[nval] = bitn;
      end
      nval++;
    end
    frame_i = f;
    data_i  = d;
    bitn++;
  endtask

  task automatic do_reset(input logic [1:0] fmt, input logic [1:0] wl,
                          input logic [2:0] slot, input logic tdm8);
    rst_n    = 1'b0;
    cfg_fmt  = fmt;
    cfg_wlen = wl;
    cfg_slot = slot;
    cfg_tdm8 = tdm8;
    wbits    = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 20 : 24;
    idle_lvl = (fmt == 2'd0);
    repeat (3) tick(idle_lvl, 1'b0);
    rst_n = 1'b1;
    repeat (8) tick(idle_lvl, 1'b0);
    nval = 0;
  endtask

  task automatic send_stereo(input int ratio, input logic [23:0] lw, input logic [23:0] rw);
    int half  = ratio / 2;
    int start = bitn;
    int plast = (cfg_fmt == 2'd1) ? wbits - 1 : (cfg_fmt == 2'd0) ? wbits : half - 1;
    exp_vb = start + (cfg_slot[0] ? half : 0) + plast + 2;
    for (int b = 0; b < ratio; b++) begin
      int h = b / half;
      int p = b % half;
      int i;
      logic f;
      logic d;
      logic [23:0] w = h ? rw : lw;
      f = (cfg_fmt == 2'd0) ? (h == 1) : (h == 0);
      if (cfg_fmt == 2'd1)      i = p;
      else if (cfg_fmt == 2'd0) i = p - 1;
      else                      i = p - (half - wbits);
      d = (i >= 0 && i < wbits) ? w[wbits-1-i] : 1'b1;
      tick(f, d);
    end
  endtask

  task automatic send_tdm(input int slots);
    int start = bitn;
    exp_vb = start + 32 * int'(cfg_slot) + 23 + 2;
    for (int b = 0; b < slots * 32; b++) begin
      tick(b == 0, tdm_w[b/32][31 - (b % 32)]);
    end
  endtask

  task automatic tail(input logic f0, input logic f1);
    tick(f0, 1'b0);
    repeat (5) tick(f1, 1'b0);
    @(negedge clk);
  endtask

  function automatic logic [23:0] align(input logic [23:0] w, input int n);
    return w << (24 - n);
  endfunction

  task automatic t_reset();
    do_reset(2'd1, 2'd0, 3'd0, 1'b0);
    chk("R1 sample after reset", {8'h0, sample_o}, 32'h0);
    chk("R1 valid after reset", {31'h0, sample_vld_o}, 32'h0);
    chk("R1 err after reset", {31'h0, frame_err_o}, 32'h0);
    repeat (20) tick(1'b0, 1'b1);
    chk("R1 no strobe while idle", nval, 0);
  endtask

  task automatic t_lj();
    do_reset(2'd1, 2'd1, 3'd0, 1'b0);
    repeat (3) send_stereo(64, 24'h0ABCDE, 24'h012345);
    tail(1'b1, 1'b1);
    chk("R10 LJ strobe count (first frame withheld)", nval, 2);
    chk("R2 R7 LJ left 20-bit word", {8'h0, vs[1]}, {8'h0, align(24'h0ABCDE, 20)});
    chk("R8 LJ strobe timing", vb[1], exp_vb);
    chk("R9 LJ err clear", {31'h0, frame_err_o}, 32'h0);
  endtask

  task automatic t_i2s();
    do_reset(2'd0, 2'd2, 3'd1, 1'b0);
    repeat (3) send_stereo(64, 24'h5A5A5A, 24'hC3A591);
    tail(1'b0, 1'b0);
    chk("R3 R5 I2S strobe count", nval, 2);
    chk("R3 R5 I2S right word", {8'h0, vs[1]}, 32'h00C3A591);
    chk("R8 I2S strobe timing", vb[1], exp_vb);
  endtask

  task automatic t_rj64();
    do_reset(2'd2, 2'd0, 3'd0, 1'b0);
    repeat (3) send_stereo(64, 24'h77BEEF, 24'h001234);
    tail(1'b1, 1'b1);
    chk("R4 RJ64 strobe count", nval, 2);
    chk("R4 R7 RJ 16-bit left word", {8'h0, vs[1]}, 32'h00BEEF00);
    chk("R8 RJ64 strobe timing", vb[1], exp_vb);
  endtask

  task automatic t_rj48();
    do_reset(2'd2, 2'd1, 3'd1, 1'b0);
    repeat (3) send_stereo(48, 24'h0AAAAA, 24'h0F1E2D);
    tail(1'b1, 1'b1);
    chk("R4 R5 RJ48 strobe count", nval, 2);
    chk("R4 R5 RJ48 right word", {8'h0, vs[1]}, {8'h0, align(24'h0F1E2D, 20)});
    chk("R8 RJ48 strobe timing", vb[1], exp_vb);
    chk("R9 ratio 48 legal", {31'h0, frame_err_o}, 32'h0);
  endtask

  task automatic t_lj32();
    do_reset(2'd1, 2'd0, 3'd0, 1'b0);
    repeat (3) send_stereo(32, 24'h00A55A, 24'h00FFFF);
    tail(1'b1, 1'b1);
    chk("R9 ratio 32 legal", {31'h0, frame_err_o}, 32'h0);
    chk("R2 LJ32 word", {8'h0, vs[1]}, 32'h00A55A00);
    chk("R10 LJ32 strobe count", nval, 2);
  endtask

  task automatic t_tdm(input logic tdm8, input logic [2:0] slot);
    do_reset(2'd3, 2'd0, slot, tdm8);
    for (int s = 0; s < 8; s++) tdm_w[s] = 32'h13579BDF ^ (32'(s) * 32'h11111111);
    repeat (3) send_tdm(tdm8 ? 8 : 4);
    tail(1'b1, 1'b0);
    chk("R6 TDM strobe count", nval, 2);
    chk("R6 TDM slot upper 24 bits", {8'h0, vs[1]}, {8'h0, tdm_w[slot][31:8]});
    chk("R8 TDM strobe timing", vb[1], exp_vb);
    chk("R9 TDM length legal", {31'h0, frame_err_o}, 32'h0);
  endtask

  task automatic t_err_stereo();
    int snap;
    do_reset(2'd1, 2'd0, 3'd0, 1'b0);
    send_stereo(64, 24'h001111, 24'h002222);
    send_stereo(64, 24'h003333, 24'h004444);
    send_stereo(40, 24'h005555, 24'h006666);
    snap = nval;
    chk("R10 strobes before bad frame ends", snap, 2);
    send_stereo(64, 24'h007777, 24'h008888);
    chk("R9 err set after 40-bit frame", {31'h0, frame_err_o}, 32'h1);
    chk("R10 no strobe in frame after bad one", nval, snap);
    send_stereo(64, 24'h009999, 24'h00AAAA);
    tail(1'b1, 1'b1);
    chk("R9 err cleared after legal frame", {31'h0, frame_err_o}, 32'h0);
    chk("R10 strobe resumes", nval, snap + 1);
    chk("R2 word after recovery", {8'h0, vs[nval-1]}, 32'h00999900);
  endtask

  task automatic t_err_tdm();
    do_reset(2'd3, 2'd0, 3'd1, 1'b1);
    for (int s = 0; s < 8; s++) tdm_w[s] = 32'hCAFE0000 + 32'(s);
    repeat (3) send_tdm(4);
    tail(1'b1, 1'b0);
    chk("R9 128-bit frame illegal with 8 slots", {31'h0, frame_err_o}, 32'h1);
    chk("R10 no strobe on illegal TDM frames", nval, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    frame_i  = 1'b0;
    data_i   = 1'b0;
    cfg_fmt  = 2'd1;
    cfg_wlen = 2'd0;
    cfg_slot = 3'd0;
    cfg_tdm8 = 1'b0;
    t_reset();
    t_lj();
    t_i2s();
    t_rj64();
    t_rj48();
    t_lj32();
    t_tdm(1'b1, 3'd5);
    t_tdm(1'b0, 3'd2);
    t_err_stereo();
    t_err_tdm();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule